// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit and Stack Views

This block holds the 128-byte internal data store of a small 8-bit controller. The same bytes can be reached in four ways at once: by plain byte address, as one of eight working registers in one of four banks, as single bits in a sixteen-byte bit region, and as a stack through a pointer that is incremented before a push stores and decremented after a pop reads.

All read ports are combinational views of the current contents. All writes, bit updates and pointer moves take effect on the rising clock edge. Each cycle carries at most one store into the array. When several write sources are active together, a fixed priority picks the one that goes ahead. The stack pointer is eight bits wide. A stack access that falls above the top byte (7FH) is reported on an error output and is never stored.

Top module: `bankedDataRam`

## Requirements
- R1: After an active-low reset, the stack pointer reads 07H and every byte of the store reads 00H.
- R2: `byteRdData` always shows the byte at `byteAddr`. A byte write stores `byteWrData` at `byteAddr` on the clock edge.
- R3: Register `regNum` = n in bank `regBank` = k is the byte at address 8*k + n, for both reads and writes on the register port.
- R4: Bit address b (0..127) selects bit position b mod 8 of the byte at address 20H + (b div 8). `bitRdData` shows that bit.
- R5: A bit set forces the selected bit to 1 and a bit clear forces it to 0, leaving the other seven bits of the byte unchanged. When both are asserted, set wins.
- R6: Only one write is stored per cycle, chosen in this priority order: byte port, then register port, then push, then bit update. Lower-priority writes in that cycle are dropped, including a bit update aimed at the byte being written by the byte port.
- R7: A push (with no load) first increments the stack pointer, then stores `pushData` at the new pointer value.
- R8: `popData` shows the byte at the current stack pointer. A pop (with no load or push) decrements the pointer on the edge.
- R9: Pointer updates follow the priority load, then push, then pop. `spLoad` sets the pointer to `spLoadVal`, and a push or pop asserted in that cycle has no effect.
- R10: A push whose incremented pointer is 80H or above, or a pop while the pointer is 80H or above, raises `stackErr` in that cycle. Such a push stores nothing, and such a pop reads 00H. The pointer still moves, wrapping modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| byteAddr | input | 7 | Byte port address |
| byteWrData | input | 8 | Byte port write data |
| byteWrEn | input | 1 | Byte port write strobe |
| byteRdData | output | 8 | Byte at byteAddr |
| regNum | input | 3 | Register number within the bank |
| regBank | input | 2 | Bank select |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdData | output | 8 | Selected register contents |
| bitAddr | input | 7 | Bit address |
| bitSet | input | 1 | Set selected bit |
| bitClr | input | 1 | Clear selected bit |
| bitRdData | output | 1 | Selected bit value |
| pushEn | input | 1 | Push command |
| pushData | input | 8 | Data to push |
| popEn | input | 1 | Pop command |
| popData | output | 8 | Byte at the stack top |
| spLoad | input | 1 | Load stack pointer |
| spLoadVal | input | 8 | Value to load |
| spOut | output | 8 | Current stack pointer |
| stackErr | output | 1 | Stack access out of range this cycle |

## Verification
The assertions expect the inputs to be settled and free of unknowns at each rising edge. They also expect the reset to be released away from an edge. The bench meets both conditions by driving every input on the falling edge from a single process, and by releasing reset between edges. The random phase keeps the pointer inside the store by choosing pops whenever it nears 7FH. It also mixes single operations with occasional same-cycle collisions. Overflow, reads at 80H and the wrap from FFH to 00H are reached only in directed steps.

// File: rtl/ramPkg.sv
package ramPkg;
  localparam int DataW  = 8;
  localparam int AddrW  = 7;
  localparam int Depth  = 1 << AddrW;
  localparam int SpW    = 8;
  localparam int BankW  = 2;
  localparam int RegW   = 3;
  localparam int BitPosW = 3;
  localparam logic [AddrW-1:0] BitBase = 7'h20;
  localparam logic [SpW-1:0]   SpReset = 8'h07;

  typedef struct packed {
    logic                wrEn;
    logic                bitMode;
    logic [AddrW-1:0]    wrAddr;
    logic [DataW-1:0]    wrData;
    logic [BitPosW-1:0]  bitPos;
    logic                bitVal;
    logic                spLd;
    logic                spInc;
    logic                spDec;
    logic [SpW-1:0]      spVal;
  } ramStrobe_t;
endpackage

// File: rtl/ramControl.sv
module ramControl
  import ramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [AddrW-1:0]  byteAddr,
  input  logic [DataW-1:0]  byteWrData,
  input  logic              byteWrEn,
  input  logic [RegW-1:0]   regNum,
  input  logic [BankW-1:0]  regBank,
  input  logic [DataW-1:0]  regWrData,
  input  logic              regWrEn,
  input  logic [AddrW-1:0]  bitAddr,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic              pushEn,
  input  logic [DataW-1:0]  pushData,
  input  logic              popEn,
  input  logic              spLoad,
  input  logic [SpW-1:0]    spLoadVal,
  input  logic [SpW-1:0]    spCur,
  output logic [AddrW-1:0]  regAddr,
  output logic [AddrW-1:0]  bitByteAddr,
  output logic [BitPosW-1:0] bitPosOut,
  output logic              stackErr,
  output ramStrobe_t        strobe
);
  logic [SpW-1:0] spNext;
  logic pushOk, popOk, doPush, doPop;
  logic selByte, selReg, selPush, selBit;

  assign regAddr     = {{(AddrW-BankW-RegW){1'b0}}, regBank, regNum};
  assign bitByteAddr = BitBase | AddrW'(bitAddr[AddrW-1:BitPosW]);
  assign bitPosOut   = bitAddr[BitPosW-1:0];

  assign spNext = spCur + 1'b1;
  assign pushOk = ~spNext[SpW-1];
  assign popOk  = ~spCur[SpW-1];
  assign doPush = pushEn & ~spLoad;
  assign doPop  = popEn & ~spLoad & ~pushEn;

  assign selByte = byteWrEn;
  assign selReg  = ~selByte & regWrEn;
  assign selPush = ~selByte & ~selReg & doPush & pushOk;
  assign selBit  = ~selByte & ~selReg & ~selPush & (bitSet | bitClr);

  assign stackErr = (doPush & ~pushOk) | (doPop & ~popOk);

  always_comb begin
    strobe         = '0;
    strobe.wrEn    = selByte | selReg | selPush | selBit;
    strobe.bitMode = selBit;
    strobe.bitPos  = bitPosOut;
    strobe.bitVal  = bitSet;
    strobe.spLd    = spLoad;
    strobe.spInc   = doPush;
    strobe.spDec   = doPop;
    strobe.spVal   = spLoadVal;
    if (selByte) begin
      strobe.wrAddr = byteAddr;
      strobe.wrData = byteWrData;
    end else if (selReg) begin
      strobe.wrAddr = regAddr;
      strobe.wrData = regWrData;
    end else if (selPush) begin
      strobe.wrAddr = spNext[AddrW-1:0];
      strobe.wrData = pushData;
    end else begin
      strobe.wrAddr = bitByteAddr;
      strobe.wrData = '0;
    end
  end

  AST_ERR_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |-> !(strobe.wrEn && !byteWrEn && !regWrEn && !strobe.bitMode)); // R10
  AST_BYTE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    byteWrEn |-> (strobe.wrAddr == byteAddr && !strobe.bitMode)); // R6
endmodule

// File: rtl/ramDatapath.sv
module ramDatapath
  import ramPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ramStrobe_t         strobe,
  input  logic [AddrW-1:0]   byteAddr,
  input  logic [AddrW-1:0]   regAddr,
  input  logic [AddrW-1:0]   bitByteAddr,
  input  logic [BitPosW-1:0] bitPos,
  output logic [DataW-1:0]   byteRdData,
  output logic [DataW-1:0]   regRdData,
  output logic               bitRdData,
  output logic [DataW-1:0]   popData,
  output logic [SpW-1:0]     spCur
);
  logic [DataW-1:0] mem [Depth];
  logic [DataW-1:0] bitByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) mem[i] <= '0;
    end else if (strobe.wrEn) begin
      if (strobe.bitMode) mem[strobe.wrAddr][strobe.bitPos] <= strobe.bitVal;
      else                mem[strobe.wrAddr] <= strobe.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              spCur <= SpReset;
    else if (strobe.spLd)   spCur <= strobe.spVal;
    else if (strobe.spInc)  spCur <= spCur + 1'b1;
    else if (strobe.spDec)  spCur <= spCur - 1'b1;
  end

  assign byteRdData = mem[byteAddr];
  assign regRdData  = mem[regAddr];
  assign bitByte    = mem[bitByteAddr];
  assign bitRdData  = bitByte[bitPos];
  assign popData    = spCur[SpW-1] ? '0 : mem[spCur[AddrW-1:0]];

  AST_BYTE_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.bitMode) |=> mem[$past(strobe.wrAddr)] == $past(strobe.wrData)); // R2
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.bitMode) |=>
      $countones(mem[$past(strobe.wrAddr)] ^ $past(mem[strobe.wrAddr])) <= 1); // R5
endmodule

// File: rtl/bankedDataRam.sv
module bankedDataRam
  import ramPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] byteAddr,
  input  logic [7:0] byteWrData,
  input  logic       byteWrEn,
  output logic [7:0] byteRdData,
  input  logic [2:0] regNum,
  input  logic [1:0] regBank,
  input  logic [7:0] regWrData,
  input  logic       regWrEn,
  output logic [7:0] regRdData,
  input  logic [6:0] bitAddr,
  input  logic       bitSet,
  input  logic       bitClr,
  output logic       bitRdData,
  input  logic       pushEn,
  input  logic [7:0] pushData,
  input  logic       popEn,
  output logic [7:0] popData,
  input  logic       spLoad,
  input  logic [7:0] spLoadVal,
  output logic [7:0] spOut,
  output logic       stackErr
);
  ramStrobe_t        strobe;
  logic [AddrW-1:0]  regAddr, bitByteAddr;
  logic [BitPosW-1:0] bitPos;

  ramControl u_ctrl (
    .clk, .rstN, .byteAddr, .byteWrData, .byteWrEn, .regNum, .regBank,
    .regWrData, .regWrEn, .bitAddr, .bitSet, .bitClr, .pushEn, .pushData,
    .popEn, .spLoad, .spLoadVal, .spCur(spOut), .regAddr, .bitByteAddr,
    .bitPosOut(bitPos), .stackErr, .strobe
  );

  ramDatapath u_dp (
    .clk, .rstN, .strobe, .byteAddr, .regAddr, .bitByteAddr, .bitPos,
    .byteRdData, .regRdData, .bitRdData, .popData, .spCur(spOut)
  );

  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    spLoad |=> spOut == $past(spLoadVal)); // R9
  AST_SP_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !spLoad) |=> spOut == $past(spOut) + 8'd1); // R7
  AST_SP_POP: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && !spLoad) |=> spOut == $past(spOut) - 8'd1); // R8
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!popEn && !pushEn && !spLoad) |=> $stable(spOut)); // R9
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !spLoad && !byteWrEn && !regWrEn && !stackErr) |=> popData == $past(pushData)); // R7
endmodule

// File: tb/sim_bankedDataRam.sv
module sim_bankedDataRam;
  logic clk = 0, rstN = 0;
  logic [6:0] byteAddr = 0; logic [7:0] byteWrData = 0; logic byteWrEn = 0;
  logic [7:0] byteRdData;
  logic [2:0] regNum = 0; logic [1:0] regBank = 0; logic [7:0] regWrData = 0;
  logic regWrEn = 0; logic [7:0] regRdData;
  logic [6:0] bitAddr = 0; logic bitSet = 0, bitClr = 0; logic bitRdData;
  logic pushEn = 0; logic [7:0] pushData = 0; logic popEn = 0; logic [7:0] popData;
  logic spLoad = 0; logic [7:0] spLoadVal = 0; logic [7:0] spOut; logic stackErr;

  int checks = 0, fails = 0;
  logic [7:0] model [128];
  logic [7:0] refSp;

  always #4 clk = ~clk;

  bankedDataRam u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int regAddrOf(input int bank, input int num);
    return bank * 8 + num;
  endfunction

  function automatic int bitByteOf(input int b);
    return 32 + b / 8;
  endfunction

  function automatic logic expErr();
    logic [7:0] nxt = refSp + 8'd1;
    if (spLoad) return 1'b0;
    if (pushEn) return nxt >= 8'h80;
    if (popEn) return refSp >= 8'h80;
    return 1'b0;
  endfunction

  task automatic updateModel();
    logic [7:0] nxt = refSp + 8'd1;
    logic pushStore = pushEn && !spLoad && nxt < 8'h80;
    if (byteWrEn) model[byteAddr] = byteWrData;
    else if (regWrEn) model[regAddrOf(regBank, regNum)] = regWrData;
    else if (pushStore) model[nxt[6:0]] = pushData;
    else if (bitSet || bitClr) model[bitByteOf(bitAddr)][bitAddr % 8] = bitSet;
    if (spLoad) refSp = spLoadVal;
    else if (pushEn) refSp = refSp + 8'd1;
    else if (popEn) refSp = refSp - 8'd1;
  endtask

  task automatic idle();
    byteWrEn = 0; regWrEn = 0; bitSet = 0; bitClr = 0;
    pushEn = 0; popEn = 0; spLoad = 0;
  endtask

  // inputs are set after a falling edge; outputs checked 1 ns later, model advanced at the rising edge
  task automatic step();
    #1;
    check("R2 byte read", byteRdData, model[byteAddr]);
    check("R3 register read", regRdData, model[regAddrOf(regBank, regNum)]);
    check("R4 bit read", {7'd0, bitRdData}, {7'd0, model[bitByteOf(bitAddr)][bitAddr % 8]});
    check("R8 pop data", popData, refSp >= 8'h80 ? 8'h00 : model[refSp[6:0]]);
    check("R10 stack error", {7'd0, stackErr}, {7'd0, expErr()});
    check("R7 stack pointer", spOut, refSp);
    @(posedge clk);
    updateModel();
    @(negedge clk);
    idle();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    refSp = 8'h07;
    #6 rstN = 1;
    @(negedge clk);
    // R1: reset contents and pointer
    check("R1 reset pointer", spOut, 8'h07);
    byteAddr = 7'h7F; #1 check("R1 reset byte", byteRdData, 8'h00);
    byteAddr = 7'h00; #1 check("R1 reset byte", byteRdData, 8'h00);
    @(negedge clk);

    // R3: bank 2 register 5 is byte 15H
    regBank = 2; regNum = 5; regWrData = 8'hA5; regWrEn = 1; step();
    byteAddr = 7'h15; #1 check("R3 bank map", byteRdData, 8'hA5);
    step();

    // R4/R5: bit 67H is bit 7 of byte 2CH
    byteAddr = 7'h2C; byteWrData = 8'h11; byteWrEn = 1; step();
    bitAddr = 7'h67; bitSet = 1; step();
    byteAddr = 7'h2C; #1 check("R5 bit set", byteRdData, 8'h91);
    bitAddr = 7'h60; bitClr = 1; step();
    byteAddr = 7'h2C; #1 check("R5 bit clear", byteRdData, 8'h90);
    bitAddr = 7'h61; bitSet = 1; bitClr = 1; step();
    byteAddr = 7'h2C; #1 check("R5 set wins", byteRdData, 8'h92);

    // R6: byte write beats bit write on the same byte
    byteAddr = 7'h2C; byteWrData = 8'h0F; byteWrEn = 1; bitAddr = 7'h67; bitSet = 1; step();
    byteAddr = 7'h2C; #1 check("R6 byte wins", byteRdData, 8'h0F);
    // R6: register write beats push
    regBank = 0; regNum = 1; regWrData = 8'h3C; regWrEn = 1; pushEn = 1; pushData = 8'hEE; step();
    byteAddr = 7'h08; #1 check("R6 push dropped", byteRdData, 8'h00);

    // R7/R8: push then pop reverses order
    spLoad = 1; spLoadVal = 8'h07; step();
    pushEn = 1; pushData = 8'h15; step();
    pushEn = 1; pushData = 8'h0F; step();
    popEn = 1; step();
    popEn = 1; step();

    // R9: load overrides push, push overrides pop
    spLoad = 1; spLoadVal = 8'h40; pushEn = 1; pushData = 8'h77; step();
    check("R9 load wins", spOut, 8'h40);
    pushEn = 1; popEn = 1; pushData = 8'h55; step();
    check("R9 push over pop", spOut, 8'h41);

    // R10: overflow, read above top, wrap
    spLoad = 1; spLoadVal = 8'h7E; step();
    pushEn = 1; pushData = 8'hC3; step();
    pushEn = 1; pushData = 8'hC4; step();
    check("R10 pointer moved", spOut, 8'h80);
    popEn = 1; step();
    spLoad = 1; spLoadVal = 8'hFF; step();
    pushEn = 1; pushData = 8'h5A; step();
    byteAddr = 7'h00; #1 check("R10 wrap store", byteRdData, 8'h5A);
    step();

    // random phase
    void'($urandom(32'h1234_5678));
    spLoad = 1; spLoadVal = 8'h30; step();
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      byteAddr = 7'($urandom); bitAddr = 7'($urandom);
      regBank = 2'($urandom); regNum = 3'($urandom);
      byteWrData = 8'($urandom); regWrData = 8'($urandom); pushData = 8'($urandom);
      case (op)
        0, 1: byteWrEn = 1;
        2, 3: regWrEn = 1;
        4: bitSet = 1;
        5: bitClr = 1;
        6: if (refSp < 8'h7C) pushEn = 1; else popEn = 1;
        7: if (refSp > 8'h08 && refSp < 8'h80) popEn = 1; else pushEn = 1;
        8: begin byteWrEn = 1; bitSet = 1; if (refSp < 8'h7C) pushEn = 1; end
        default: ;
      endcase
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule